// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This block decides which clocks of one processor core run. It has three operating states: run, idle and standby. The core asks for low power by executing its idle instruction, which shows up here as a one-cycle request, together with a 2-bit mode field. In idle only the CPU clock stops, so peripherals on the system clock keep working. In standby the system clock and the clock input are stopped as well. Each mode has its own set of wake sources. Idle ends on an enabled interrupt or the non-maskable interrupt. Standby ends on the inter-processor interrupt or on one of 64 GPIO lines, chosen by a select field and filtered by a programmable low-level qualifier.

The whole block runs on an always-on oscillator clock, so the qualifier and the sequencer keep working while every gated clock is off. The three outputs are clock enables for downstream gating cells. Each one comes straight from a flop, so it only changes on a clock edge. Standby stops the clocks one step per cycle, innermost first, and restarts them in the reverse order. When the CPU clock comes back, a one-cycle wake interrupt request can be raised. The block keeps no program state: the core resumes at the instruction after its idle instruction simply because its clock starts again.

The interface is control-only. No data stream passes through the block, so there is no valid/ready pair. All pins are plain levels, except `lp_req` and `wake_irq`, which are single-cycle pulses.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, `cpuclk_en`, `sysclk_en` and `clkin_en` are 1 and `wake_irq` is 0.
- R2: An `lp_req` in run with `lpm_ctrl[1:0]` equal to 00, 10 or 11 selects idle. On the next cycle `cpuclk_en` is 0, while `sysclk_en` and `clkin_en` stay 1.
- R3: Idle ends when any bit of `irq_pend & irq_en` is 1 or `nmi` is 1. On the next cycle `cpuclk_en` is 1 again. A pending but masked interrupt, `ipc_irq` and the GPIO lines leave idle unchanged.
- R4: An `lp_req` in run with `lpm_ctrl[1:0]` equal to 01 selects standby. The enables then fall one per cycle: `cpuclk_en` on the first cycle after the request, `sysclk_en` on the second and `clkin_en` on the third.
- R5: Standby ends only on `ipc_irq` or on a qualified GPIO wake. `nmi` and enabled interrupts are ignored. On release, `clkin_en` rises first, then `sysclk_en` one cycle later, then `cpuclk_en` one cycle after that.
- R6: The standby wake line is `gpio_in[wake_sel]`. Activity on any other GPIO line has no effect.
- R7: The wake line is active low. It is qualified once it has been sampled low for Q+2 consecutive oscillator cycles, where Q = `lpm_ctrl[7:2]`. Any high sample restarts the count. With the two default synchronizer stages, `clkin_en` rises Q+5 cycles after the line is first driven low.
- R8: `wake_irq` is a one-cycle pulse in the cycle in which `cpuclk_en` returns to 1 after idle or standby. It is raised only when `wake_irq_en` is 1.
- R9: A request is ignored, and the block stays in run, when a wake source of the requested mode is already active at the request.
- R10: An `lp_req` that arrives while the block is not in run is ignored.
- R11: At all times, `clkin_en` = 0 implies `sysclk_en` = 0, and `sysclk_en` = 0 implies `cpuclk_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_req | input | 1 | Pulse raised when the core executes its idle instruction |
| lpm_ctrl | input | 8 | [1:0] mode (01 standby, otherwise idle); [7:2] qualification value Q |
| wake_sel | input | 6 | Index of the GPIO line used as standby wake |
| gpio_in | input | 64 | GPIO lines, active-low wake |
| irq_pend | input | 16 | Pending maskable interrupts |
| irq_en | input | 16 | Interrupt enables |
| nmi | input | 1 | Non-maskable interrupt |
| ipc_irq | input | 1 | Inter-processor interrupt |
| wake_irq_en | input | 1 | Enables the wake interrupt pulse |
| cpuclk_en | output | 1 | CPU clock enable |
| sysclk_en | output | 1 | System clock enable |
| clkin_en | output | 1 | Clock-input enable |
| wake_irq | output | 1 | Wake interrupt request pulse |

## Verification
The bench builds the block with its default parameters: 64 GPIO lines, 16 interrupts and two synchronizer stages. Under these defaults the Q+5 wake latency is an exact cycle count. At run time the bench sets the qualification field to 3, 0 and 63. These values cover the two-sample minimum, a mid value with a burst that is one sample short and is broken by a single high sample, and the longest 65-sample window. The wake line is moved between indices 5, 63 and 0, so both ends of the mux are reached.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam logic [1:0] MODE_STANDBY = 2'b01;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_SB_CPU,
    ST_SB_SYS,
    ST_STANDBY,
    ST_RW_IN,
    ST_RW_SYS
  } lpm_state_t;

  typedef struct packed {
    logic in_en;
    logic sys_en;
    logic cpu_en;
  } clk_en_t;

  function automatic logic is_standby(input logic [1:0] mode);
    return mode == MODE_STANDBY;
  endfunction

  function automatic clk_en_t enables_for(input lpm_state_t st);
    clk_en_t e;
    case (st)
      ST_RUN:     e = '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b1};
      ST_IDLE:    e = '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b0};
      ST_SB_CPU:  e = '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b0};
      ST_SB_SYS:  e = '{in_en: 1'b1, sys_en: 1'b0, cpu_en: 1'b0};
      ST_STANDBY: e = '{in_en: 1'b0, sys_en: 1'b0, cpu_en: 1'b0};
      ST_RW_IN:   e = '{in_en: 1'b1, sys_en: 1'b0, cpu_en: 1'b0};
      ST_RW_SYS:  e = '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b0};
      default:    e = '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
  parameter int NUM_GPIO    = 64,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_GPIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [SEL_W-1:0]    wake_sel,
  output logic                line_sync
);

  logic picked;
  assign picked = gpio_in[wake_sel];

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= picked;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], picked};
      end
    end
  endgenerate

  assign line_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int QUAL_W = 6,
  localparam int CNT_W = QUAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic [QUAL_W-1:0] qual_cfg,
  output logic              qual_ok
);

  logic [CNT_W-1:0] low_run_q;
  logic [CNT_W-1:0] need;

  assign need = {1'b0, qual_cfg} + CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run_q <= '0;
    else if (line_sync)        low_run_q <= '0;
    else if (low_run_q != '1)  low_run_q <= low_run_q + CNT_W'(1);
  end

  assign qual_ok = (low_run_q >= need);

  // R7
  restart_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync |=> !qual_ok);

endmodule

// File: rtl/lpm_gate_seq.sv
module lpm_gate_seq
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic sb_mode,
  input  logic idle_wake,
  input  logic sb_wake,
  input  logic wake_irq_en,
  output logic cpuclk_en,
  output logic sysclk_en,
  output logic clkin_en,
  output logic wake_irq
);

  lpm_state_t state_q, state_d;
  clk_en_t    en_q, en_d;
  logic       irq_d, irq_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (lp_req) begin
          if (sb_mode) begin
            if (!sb_wake) state_d = ST_SB_CPU;
          end else if (!idle_wake) begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE:    if (idle_wake) state_d = ST_RUN;
      ST_SB_CPU:  state_d = ST_SB_SYS;
      ST_SB_SYS:  state_d = ST_STANDBY;
      ST_STANDBY: if (sb_wake) state_d = ST_RW_IN;
      ST_RW_IN:   state_d = ST_RW_SYS;
      ST_RW_SYS:  state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  assign en_d  = enables_for(state_d);
  assign irq_d = wake_irq_en && (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      en_q    <= '{in_en: 1'b1, sys_en: 1'b1, cpu_en: 1'b1};
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
    end
  end

  assign cpuclk_en = en_q.cpu_en;
  assign sysclk_en = en_q.sys_en;
  assign clkin_en  = en_q.in_en;
  assign wake_irq  = irq_q;

  // R11
  sys_off_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_en |-> !cpuclk_en);

  // R11
  in_off_sys_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clkin_en |-> !sysclk_en);

  // R4
  in_stop_after_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkin_en) |-> $past(!sysclk_en));

  // R5
  sys_start_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> $past(clkin_en));

  // R5
  cpu_start_after_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpuclk_en) |-> $past(sysclk_en));

  // R8
  wake_irq_with_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $rose(cpuclk_en));

  // R9
  idle_req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && lp_req && !sb_mode && idle_wake |=> cpuclk_en);

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_GPIO    = 64,
  parameter int NUM_IRQ     = 16,
  parameter int QUAL_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_GPIO),
  localparam int CTRL_W     = QUAL_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_req,
  input  logic [CTRL_W-1:0]   lpm_ctrl,
  input  logic [SEL_W-1:0]    wake_sel,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic                nmi,
  input  logic                ipc_irq,
  input  logic                wake_irq_en,
  output logic                cpuclk_en,
  output logic                sysclk_en,
  output logic                clkin_en,
  output logic                wake_irq
);

  logic line_sync;
  logic qual_ok;
  logic idle_wake;
  logic sb_wake;

  lpm_wake_sel #(
    .NUM_GPIO    (NUM_GPIO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpio_in   (gpio_in),
    .wake_sel  (wake_sel),
    .line_sync (line_sync)
  );

  lpm_wake_qual #(
    .QUAL_W (QUAL_W)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_sync),
    .qual_cfg  (lpm_ctrl[CTRL_W-1:2]),
    .qual_ok   (qual_ok)
  );

  assign idle_wake = (|(irq_pend & irq_en)) | nmi;
  assign sb_wake   = qual_ok | ipc_irq;

  lpm_gate_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_req      (lp_req),
    .sb_mode     (is_standby(lpm_ctrl[1:0])),
    .idle_wake   (idle_wake),
    .sb_wake     (sb_wake),
    .wake_irq_en (wake_irq_en),
    .cpuclk_en   (cpuclk_en),
    .sysclk_en   (sysclk_en),
    .clkin_en    (clkin_en),
    .wake_irq    (wake_irq)
  );

endmodule

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_req = 1'b0;
  logic [7:0]  lpm_ctrl = {6'd3, 2'b00};
  logic [5:0]  wake_sel = 6'd5;
  logic [63:0] gpio_in = '1;
  logic [15:0] irq_pend = '0;
  logic [15:0] irq_en = '0;
  logic        nmi = 1'b0;
  logic        ipc_irq = 1'b0;
  logic        wake_irq_en = 1'b1;
  logic        cpuclk_en, sysclk_en, clkin_en, wake_irq;

  lpm_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .lpm_ctrl(lpm_ctrl),
    .wake_sel(wake_sel), .gpio_in(gpio_in), .irq_pend(irq_pend),
    .irq_en(irq_en), .nmi(nmi), .ipc_irq(ipc_irq), .wake_irq_en(wake_irq_en),
    .cpuclk_en(cpuclk_en), .sysclk_en(sysclk_en), .clkin_en(clkin_en),
    .wake_irq(wake_irq)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected snapshot {clkin_en, sysclk_en, cpuclk_en, wake_irq}
  typedef struct {
    int         at;
    logic [3:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];

  task automatic expect_at(input int k, input logic in_e, input logic sys_e,
                           input logic cpu_e, input logic irq, input string tag);
    exp_item_t it;
    it.at  = cyc + k;
    it.exp = {in_e, sys_e, cpu_e, irq};
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as their cycle is reached
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_item_t it;
      logic [3:0] act;
      it  = exp_q.pop_front();
      act = {clkin_en, sysclk_en, cpuclk_en, wake_irq};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s cyc=%0d actual {in,sys,cpu,irq}=%b expected=%b",
                 it.tag, cyc, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R1 reset state");
    tick(2);

    // idle entry, mode 00
    lpm_ctrl = {6'd3, 2'b00};
    lp_req = 1'b1;
    expect_at(1, 1, 1, 0, 0, "R2 idle entry");
    expect_at(2, 1, 1, 0, 0, "R2 idle hold");
    tick(1); lp_req = 1'b0; tick(2);

    // masked interrupt, ipc and gpio do not end idle
    irq_pend = 16'h0001; ipc_irq = 1'b1; gpio_in[5] = 1'b0;
    expect_at(1, 1, 1, 0, 0, "R3 masked irq ignored");
    expect_at(8, 1, 1, 0, 0, "R3 ipc/gpio ignored in idle");
    tick(8); ipc_irq = 1'b0; gpio_in[5] = 1'b1;

    // enabled interrupt ends idle, wake irq pulse
    irq_en = 16'h0001;
    expect_at(1, 1, 1, 1, 1, "R3 idle exit on enabled irq / R8 pulse");
    expect_at(2, 1, 1, 1, 0, "R8 pulse one cycle");
    tick(2); irq_pend = '0; irq_en = '0; tick(6);

    // mode 11 acts as idle; a second request inside idle is ignored
    lpm_ctrl = {6'd3, 2'b11};
    lp_req = 1'b1;
    expect_at(1, 1, 1, 0, 0, "R2 mode 11 is idle");
    tick(1);
    lpm_ctrl = {6'd3, 2'b01};
    expect_at(1, 1, 1, 0, 0, "R10 request in idle ignored");
    expect_at(3, 1, 1, 0, 0, "R10 system clock kept");
    tick(1); lp_req = 1'b0; tick(2);

    // nmi ends idle with wake irq disabled
    wake_irq_en = 1'b0; nmi = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R3 nmi exit / R8 irq disabled");
    expect_at(2, 1, 1, 1, 0, "R8 no pulse when disabled");
    tick(2);

    // idle request while nmi active is ignored
    lpm_ctrl = {6'd3, 2'b00};
    lp_req = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R9 idle request blocked");
    expect_at(2, 1, 1, 1, 0, "R9 stays in run");
    tick(1); lp_req = 1'b0; tick(1); nmi = 1'b0; wake_irq_en = 1'b1; tick(1);

    // standby entry with ordered stop, nmi and irq ignored, ipc wake
    lpm_ctrl = {6'd3, 2'b01};
    lp_req = 1'b1;
    expect_at(1, 1, 1, 0, 0, "R4 cpu stops first");
    expect_at(2, 1, 0, 0, 0, "R4 sys stops second");
    expect_at(3, 0, 0, 0, 0, "R4 input clock stops third");
    tick(1); lp_req = 1'b0; tick(2);
    nmi = 1'b1; irq_pend = 16'h8000; irq_en = 16'h8000;
    expect_at(4, 0, 0, 0, 0, "R5 nmi/irq ignored in standby");
    tick(4); nmi = 1'b0; irq_pend = '0; irq_en = '0;
    ipc_irq = 1'b1;
    expect_at(1, 1, 0, 0, 0, "R5 input clock first on release");
    expect_at(2, 1, 1, 0, 0, "R5 sys second on release");
    expect_at(3, 1, 1, 1, 1, "R5 cpu third / R8 pulse");
    expect_at(4, 1, 1, 1, 0, "R8 pulse ends");
    tick(1); ipc_irq = 1'b0; tick(4);

    // standby request while ipc active is ignored
    ipc_irq = 1'b1; lp_req = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R9 standby request blocked by ipc");
    expect_at(2, 1, 1, 1, 0, "R9 stays run");
    tick(1); lp_req = 1'b0; ipc_irq = 1'b0; tick(2);

    // gpio qualification with Q=3 on line 5
    lpm_ctrl = {6'd3, 2'b01}; wake_sel = 6'd5;
    lp_req = 1'b1;
    expect_at(3, 0, 0, 0, 0, "R4 standby reached");
    tick(1); lp_req = 1'b0; tick(3);
    gpio_in[6] = 1'b0;
    expect_at(10, 0, 0, 0, 0, "R6 unselected line ignored");
    tick(10); gpio_in[6] = 1'b1;
    gpio_in[5] = 1'b0; tick(4); gpio_in[5] = 1'b1; tick(1);
    gpio_in[5] = 1'b0; tick(4); gpio_in[5] = 1'b1;
    expect_at(8, 0, 0, 0, 0, "R7 short bursts broken by high sample");
    tick(8);
    gpio_in[5] = 1'b0;
    expect_at(7, 0, 0, 0, 0, "R7 not yet qualified at Q+4");
    expect_at(8, 1, 0, 0, 0, "R7 wake at Q+5");
    expect_at(9, 1, 1, 0, 0, "R5 sys after input clock");
    expect_at(10, 1, 1, 1, 1, "R8 pulse on gpio wake");
    tick(10); gpio_in[5] = 1'b1; tick(5);

    // qualified gpio already low blocks standby request, Q=0, line 63
    lpm_ctrl = {6'd0, 2'b01}; wake_sel = 6'd63;
    gpio_in[63] = 1'b0; tick(6);
    lp_req = 1'b1;
    expect_at(1, 1, 1, 1, 0, "R9 request blocked by qualified gpio");
    expect_at(2, 1, 1, 1, 0, "R9 still run");
    tick(1); lp_req = 1'b0; tick(1); gpio_in[63] = 1'b1; tick(5);

    // Q=0 boundary: one low sample rejected, two accepted
    lp_req = 1'b1;
    expect_at(3, 0, 0, 0, 0, "R4 standby for Q=0");
    tick(1); lp_req = 1'b0; tick(3);
    gpio_in[63] = 1'b0; tick(1); gpio_in[63] = 1'b1;
    expect_at(6, 0, 0, 0, 0, "R7 single low sample rejected");
    tick(6);
    gpio_in[63] = 1'b0;
    expect_at(4, 0, 0, 0, 0, "R7 Q=0 not yet");
    expect_at(5, 1, 0, 0, 0, "R7 Q=0 wake at 5");
    expect_at(7, 1, 1, 1, 1, "R8 pulse Q=0");
    tick(7); gpio_in[63] = 1'b1; tick(5);

    // Q=63 upper bound on line 0
    lpm_ctrl = {6'd63, 2'b01}; wake_sel = 6'd0;
    lp_req = 1'b1;
    tick(1); lp_req = 1'b0; tick(3);
    gpio_in[0] = 1'b0;
    expect_at(67, 0, 0, 0, 0, "R7 Q=63 not yet at 67");
    expect_at(68, 1, 0, 0, 0, "R7 Q=63 wake at 68");
    tick(70); gpio_in[0] = 1'b1; tick(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule